// File: doc/BRIEF.md
# FPU Register-Mode Trap Controller

This block holds the two privileged configuration bits that let system software run floating-point code written for a 32-bit register layout on a core with 64-bit FP registers. It does this by trapping. One bit is the trapping-mode enable. The other is a user-access enable. While trapping mode is in force, every instruction that touches an FP register as a 32-bit single value raises a reserved-instruction exception. A handler can then emulate that instruction.

Privileged software writes both bits directly. User code can read the mode bit through FP control register 5. It can clear the bit by writing control register 5 and set it by writing control register 6, but only when the user-access bit allows it. The feature exists only when the build-time capability parameter is set. Without the capability, every related access is ignored.

The instruction decoder drives an instruction class each cycle. The block answers with a single-cycle exception strobe in that same cycle.

Top module: `fpu_mode_trap`

## Requirements
- R1: After an active-low synchronous reset, the mode bit and the user-access bit are both 0, and `privRdData` reads 0.
- R2: A privileged write loads `privWrMode` into the mode bit and `privWrUser` into the user-access bit, with no exception check. `privRdData` shows the mode bit at bit 8 and the user-access bit at bit 9, and every other bit reads 0. If a privileged write and a user set or clear arrive in the same cycle, the privileged write wins.
- R3: A user read (`userWrite`=0) of register number 5, with user access enabled, returns the mode bit in bit 0 of `userRdData` and 0 in all other bits, and raises no exception.
- R4: A user read of register 5 while user access is disabled pulses `riExc` and returns 0. A user read of any other register number returns 0 and raises no exception.
- R5: A user write (`userWrite`=1) with source index 0 and user access enabled acts on the mode bit. Register number 6 sets it, register number 5 clears it, and no exception is raised.
- R6: A user write with a nonzero source index, or to any register number other than 5 or 6, changes no state and raises no exception.
- R7: A user write to register 5 or 6 with source index 0 while user access is disabled pulses `riExc` and leaves both bits unchanged.
- R8: While trapping mode is active, a valid instruction pulses `riExc` if its class is 1 (single-precision arithmetic), 2 (32-bit FP load or store, in base or indexed form) or 3 (a move between general and FP registers). Class 0 never traps, and no class traps while the mode bit is 0.
- R9: An instruction issued in the cycle after a user write that sets or clears the mode bit sees the new mode.
- R10: With the capability parameter at 0, privileged writes leave `privRdData` at 0, user accesses return 0 and raise no exception, and no instruction traps.
- R11: `riExc` is high only in a cycle that carries an offending user access or instruction. It is low whenever `userReq` and `instValid` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| privWrEn | input | 1 | Privileged configuration write strobe |
| privWrMode | input | 1 | New value for the trapping-mode bit |
| privWrUser | input | 1 | New value for the user-access bit |
| privRdData | output | 32 | Configuration readback: mode at bit 8, user access at bit 9 |
| userReq | input | 1 | User FP control-register access valid |
| userWrite | input | 1 | 1 = write (set/clear), 0 = read |
| userRegNum | input | 5 | FP control register number |
| userSrcIdx | input | 5 | General source register index of the write |
| userRdData | output | 32 | User read result |
| instValid | input | 1 | Decoded instruction valid this cycle |
| instClass | input | 2 | 0 other, 1 SP arithmetic, 2 32-bit FP load/store, 3 GPR/FPR move |
| riExc | output | 1 | Reserved-instruction exception strobe |

## Verification
The mode bit has three observable effects: it appears in `privRdData` one cycle after a write, a permitted user read returns it in the same cycle, and it decides whether the next trappable instruction class raises `riExc`. A wrong internal bit therefore shows within one cycle on the readback, and on the exception strobe as soon as a single-precision instruction is presented. The sweep covers every mode and user-access combination against register numbers, read and write, and zero and nonzero source indices. After each access the bench issues an instruction, so a stale or lagging trap flag appears at once.

// File: rtl/fpu_mode_trap_pkg.sv
package fpu_mode_trap_pkg;

  typedef enum logic [1:0] {
    CLS_OTHER    = 2'd0,
    CLS_SP_ARITH = 2'd1,
    CLS_FP32_MEM = 2'd2,
    CLS_FP_MOVE  = 2'd3
  } instCls_e;

  localparam logic [4:0] REG_CLR_NUM = 5'd5;
  localparam logic [4:0] REG_SET_NUM = 5'd6;

  typedef struct packed {
    logic setMode;
    logic clrMode;
    logic readMode;
    logic denyRi;
  } modeStrobe_t;

endpackage

// File: rtl/fpu_mode_trap_ctrl.sv
module fpu_mode_trap_ctrl
  import fpu_mode_trap_pkg::*;
#(
  parameter bit HAS_CAP = 1'b1,
  parameter int REG_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             userReq,
  input  logic             userWrite,
  input  logic [REG_W-1:0] userRegNum,
  input  logic [REG_W-1:0] userSrcIdx,
  input  logic             instValid,
  input  logic [1:0]       instClass,
  input  logic             userEn,
  input  logic             trapFlag,
  output modeStrobe_t      strobe,
  output logic             riExc
);

  logic hitClr, hitSet, srcOk, wrPass, rdHit, instTrap;

  always_comb begin
    hitClr   = userReq && userWrite && (userRegNum == REG_CLR_NUM);
    hitSet   = userReq && userWrite && (userRegNum == REG_SET_NUM);
    srcOk    = (userSrcIdx == '0);
    wrPass   = HAS_CAP && srcOk && (hitClr || hitSet);
    rdHit    = HAS_CAP && userReq && !userWrite && (userRegNum == REG_CLR_NUM);

    strobe.setMode  = wrPass && hitSet && userEn;
    strobe.clrMode  = wrPass && hitClr && userEn;
    strobe.readMode = rdHit && userEn;
    strobe.denyRi   = (wrPass || rdHit) && !userEn;

    instTrap = instValid && trapFlag && (instClass != CLS_OTHER);
    riExc    = strobe.denyRi || instTrap;
  end

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setMode, strobe.clrMode, strobe.readMode, strobe.denyRi}));

  assert_ri_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    riExc |-> (userReq || instValid));

endmodule

// File: rtl/fpu_mode_trap_dp.sv
module fpu_mode_trap_dp
  import fpu_mode_trap_pkg::*;
#(
  parameter bit HAS_CAP  = 1'b1,
  parameter int DATA_W   = 32,
  parameter int MODE_POS = 8,
  parameter int USER_POS = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              privWrEn,
  input  logic              privWrMode,
  input  logic              privWrUser,
  input  modeStrobe_t       strobe,
  output logic              userEn,
  output logic              trapFlag,
  output logic [DATA_W-1:0] privRdData,
  output logic [DATA_W-1:0] userRdData
);

  localparam logic CAP_BIT = HAS_CAP;

  logic modeQ, userQ, trapQ;
  logic modeNext, userNext;

  always_comb begin
    if (privWrEn) begin
      modeNext = privWrMode;
      userNext = privWrUser;
    end else begin
      userNext = userQ;
      if (strobe.setMode)      modeNext = 1'b1;
      else if (strobe.clrMode) modeNext = 1'b0;
      else                     modeNext = modeQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= 1'b0;
      userQ <= 1'b0;
      trapQ <= 1'b0;
    end else begin
      modeQ <= CAP_BIT && modeNext;
      userQ <= CAP_BIT && userNext;
      trapQ <= CAP_BIT && modeNext;
    end
  end

  always_comb begin
    privRdData           = '0;
    privRdData[MODE_POS] = modeQ;
    privRdData[USER_POS] = userQ;
    userRdData           = '0;
    userRdData[0]        = strobe.readMode && modeQ;
  end

  assign userEn   = userQ;
  assign trapFlag = trapQ;

  generate
    if (HAS_CAP) begin : gCapChecks
      assert_set_seen_R9: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.setMode && !privWrEn) |=> trapFlag);
      assert_clr_seen_R9: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.clrMode && !privWrEn) |=> !trapFlag);
    end
  endgenerate

endmodule

// File: rtl/fpu_mode_trap.sv
module fpu_mode_trap
  import fpu_mode_trap_pkg::*;
#(
  parameter bit HAS_CAP  = 1'b1,
  parameter int DATA_W   = 32,
  parameter int REG_W    = 5,
  parameter int MODE_POS = 8,
  parameter int USER_POS = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              privWrEn,
  input  logic              privWrMode,
  input  logic              privWrUser,
  output logic [DATA_W-1:0] privRdData,
  input  logic              userReq,
  input  logic              userWrite,
  input  logic [REG_W-1:0]  userRegNum,
  input  logic [REG_W-1:0]  userSrcIdx,
  output logic [DATA_W-1:0] userRdData,
  input  logic              instValid,
  input  logic [1:0]        instClass,
  output logic              riExc
);

  modeStrobe_t strobe;
  logic        userEn, trapFlag;

  fpu_mode_trap_ctrl #(.HAS_CAP(HAS_CAP), .REG_W(REG_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .userReq(userReq), .userWrite(userWrite),
    .userRegNum(userRegNum), .userSrcIdx(userSrcIdx),
    .instValid(instValid), .instClass(instClass),
    .userEn(userEn), .trapFlag(trapFlag),
    .strobe(strobe), .riExc(riExc)
  );

  fpu_mode_trap_dp #(.HAS_CAP(HAS_CAP), .DATA_W(DATA_W),
                     .MODE_POS(MODE_POS), .USER_POS(USER_POS)) uDp (
    .clk(clk), .rstN(rstN),
    .privWrEn(privWrEn), .privWrMode(privWrMode), .privWrUser(privWrUser),
    .strobe(strobe), .userEn(userEn), .trapFlag(trapFlag),
    .privRdData(privRdData), .userRdData(userRdData)
  );

  assert_set_lands_R5: assert property (@(posedge clk) disable iff (!rstN)
    (userReq && userWrite && userRegNum == REG_SET_NUM && userSrcIdx == '0
     && privRdData[USER_POS] && !privWrEn) |=> privRdData[MODE_POS]);

  assert_denied_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (userReq && userWrite && (userRegNum == REG_SET_NUM || userRegNum == REG_CLR_NUM)
     && userSrcIdx == '0 && !privRdData[USER_POS] && !privWrEn) |=> $stable(privRdData));

  assert_bad_src_noop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (userReq && userWrite && userSrcIdx != '0 && !privWrEn && !instValid)
    |-> (!riExc ##1 $stable(privRdData)));

endmodule

// File: tb/fpu_mode_trap_test.sv
module fpu_mode_trap_test;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        privWrEn = 1'b0, privWrMode = 1'b0, privWrUser = 1'b0;
  logic        userReq = 1'b0, userWrite = 1'b0;
  logic [4:0]  userRegNum = '0, userSrcIdx = '0;
  logic        instValid = 1'b0;
  logic [1:0]  instClass = '0;
  logic [31:0] privRdData, userRdData, ncPrivRd, ncUserRd;
  logic        riExc, ncRiExc;

  int tests = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  fpu_mode_trap uut (
    .clk(clk), .rstN(rstN), .privWrEn(privWrEn), .privWrMode(privWrMode),
    .privWrUser(privWrUser), .privRdData(privRdData), .userReq(userReq),
    .userWrite(userWrite), .userRegNum(userRegNum), .userSrcIdx(userSrcIdx),
    .userRdData(userRdData), .instValid(instValid), .instClass(instClass),
    .riExc(riExc));

  fpu_mode_trap #(.HAS_CAP(1'b0)) uutNoCap (
    .clk(clk), .rstN(rstN), .privWrEn(privWrEn), .privWrMode(privWrMode),
    .privWrUser(privWrUser), .privRdData(ncPrivRd), .userReq(userReq),
    .userWrite(userWrite), .userRegNum(userRegNum), .userSrcIdx(userSrcIdx),
    .userRdData(ncUserRd), .instValid(instValid), .instClass(instClass),
    .riExc(ncRiExc));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfgWord(input logic m, input logic u);
    return (32'(u) << 9) | (32'(m) << 8);
  endfunction

  task automatic privWrite(input logic m, input logic u);
    @(negedge clk);
    privWrEn = 1'b1; privWrMode = m; privWrUser = u;
    @(negedge clk);
    privWrEn = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [4:0] regs [4];
    logic [4:0] srcs [3];
    regs[0] = 5'd4; regs[1] = 5'd5; regs[2] = 5'd6; regs[3] = 5'd7;
    srcs[0] = 5'd0; srcs[1] = 5'd1; srcs[2] = 5'd31;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset cfg", privRdData, 32'h0);
    chk("R1 reset read", {31'b0, riExc}, 32'h0);

    for (int m = 0; m < 2; m++)
      for (int u = 0; u < 2; u++)
        for (int ri = 0; ri < 4; ri++)
          for (int w = 0; w < 2; w++)
            for (int si = 0; si < 3; si++) begin
              logic curM, expExc, newM;
              logic [31:0] expRd;
              logic isModeReg;
              privWrite(m[0], u[0]);
              chk("R2 priv readback", privRdData, cfgWord(m[0], u[0]));
              chk("R10 nocap priv readback", ncPrivRd, 32'h0);
              curM = m[0];
              expExc = 1'b0; expRd = 32'h0; newM = curM;
              isModeReg = (regs[ri] == 5'd5) || (regs[ri] == 5'd6);
              if (w == 0) begin
                if (regs[ri] == 5'd5) begin
                  if (u != 0) expRd = {31'b0, curM};
                  else expExc = 1'b1;
                end
              end else if (isModeReg && srcs[si] == 5'd0) begin
                if (u != 0) newM = (regs[ri] == 5'd6);
                else expExc = 1'b1;
              end
              userReq = 1'b1; userWrite = w[0];
              userRegNum = regs[ri]; userSrcIdx = srcs[si];
              #1;
              if (w == 0) begin
                chk(u != 0 ? "R3 user read data" : "R4 user read data", userRdData, expRd);
                chk("R4 read exception", {31'b0, riExc}, {31'b0, expExc});
              end else if (isModeReg && srcs[si] == 5'd0) begin
                chk(u != 0 ? "R5 write exception" : "R7 denied exception",
                    {31'b0, riExc}, {31'b0, expExc});
              end else begin
                chk("R6 no-op exception", {31'b0, riExc}, 32'h0);
              end
              chk("R10 nocap exception", {31'b0, ncRiExc}, 32'h0);
              chk("R10 nocap read", ncUserRd, 32'h0);
              @(negedge clk);
              userReq = 1'b0;
              if (w == 0) chk("R3 read keeps state", privRdData, cfgWord(curM, u[0]));
              else if (!isModeReg || srcs[si] != 5'd0) chk("R6 no-op state", privRdData, cfgWord(curM, u[0]));
              else if (u == 0) chk("R7 denied state", privRdData, cfgWord(curM, u[0]));
              else chk("R5 new mode", privRdData, cfgWord(newM, u[0]));
              instValid = 1'b1; instClass = 2'd1;
              #1;
              chk("R9 next instruction sees mode", {31'b0, riExc}, {31'b0, newM});
              for (int c = 0; c < 4; c++) begin
                instClass = c[1:0];
                #1;
                chk("R8 class trap", {31'b0, riExc}, {31'b0, newM && (c != 0)});
                chk("R10 nocap no trap", {31'b0, ncRiExc}, 32'h0);
              end
              instValid = 1'b0;
              #1;
              chk("R11 idle no strobe", {31'b0, riExc}, 32'h0);
            end

    // R2: privileged write beats a same-cycle user set
    privWrite(1'b0, 1'b1);
    @(negedge clk);
    privWrEn = 1'b1; privWrMode = 1'b0; privWrUser = 1'b1;
    userReq = 1'b1; userWrite = 1'b1; userRegNum = 5'd6; userSrcIdx = 5'd0;
    @(negedge clk);
    privWrEn = 1'b0; userReq = 1'b0;
    chk("R2 priv write priority", privRdData, cfgWord(1'b0, 1'b1));

    // R1: reset clears a populated configuration
    privWrite(1'b1, 1'b1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset clears cfg", privRdData, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule